// File: doc/BRIEF.md
# Clock Source Selector and Divider

This block builds three system clocks, an auxiliary clock, a main clock and a subsystem clock, from four incoming oscillator clocks. The four are a low-frequency crystal clock, a very-low-power internal oscillator clock of about 10 kHz, a digitally controlled oscillator (DCO) clock and an optional second crystal clock. Each output has its own 3-bit source code and its own 3-bit power-of-two divide code. Both are held in registers that a register bus programs.

The registers are write-protected. A key must be written first, and any other write made while the registers are locked is dropped and noted in a sticky flag. Source changes go through a glitch-free multiplexer that hands over on falling edges, and dividers gate the selected clock so that no output phase is ever cut short.

The crystal stays off until its pin-function enable is set. From then on a stability counter watches it. While the crystal is enabled but not yet proven, a fault flag is raised, and an auxiliary clock programmed for the crystal runs from the internal oscillator instead.

Top module: `clkgen_sel_div`

## Requirements
- R1: After reset the select word (address 1) and the divide word (address 2) both read 16'h0330. The main and subsystem clocks run from the DCO divided by 8. The auxiliary clock selects the crystal, which is disabled, so it shows no edges.
- R2: Each output has a 3-bit source code: auxiliary in bits [2:0], main in [6:4], subsystem in [10:8] of address 1. Code 0 selects the crystal, 1 the internal oscillator, 2 the second crystal (the DCO when HAS_XT2 is 0), and 3 to 7 select the DCO.
- R3: The divide code sits in the same bit positions of address 2. Code n divides the selected clock by 2^n for n from 0 to MAX_DIV_LOG2 (5). Larger codes divide by 2^MAX_DIV_LOG2.
- R4: A write to address 0 whose bits [15:8] equal 8'hA5 unlocks the registers, and any other value written there locks them. Bit 0 of address 0 reads 1 while the registers are unlocked.
- R5: While the registers are locked, a write to addresses 1 to 3 changes nothing. It sets a violation flag, read at bit 1 of address 0, that only reset clears.
- R6: No output clock shows a high or low phase shorter than the shortest source half period, including across source and divider changes.
- R7: The crystal fault flag (bit 0 of address 3) is set when the pin enable rises and stays set while the crystal has not completed STABLE_CYCLES cycles since enable. It clears once that count is reached. An unlocked write of 1 to bit 0 of address 3 clears it.
- R8: While the fault flag is set and the auxiliary source code is 0, the auxiliary clock runs from the internal oscillator. Once the flag clears, it runs from the crystal.
- R9: While the pin enable is low, the crystal is gated off, so every output sourced from it shows no edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register bus clock |
| rst_ni | input | 1 | Active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| xt_pin_en_i | input | 1 | Crystal pin-function enable |
| xt_clk_i | input | 1 | Low-frequency crystal clock |
| vlo_clk_i | input | 1 | Internal low-power oscillator clock |
| dco_clk_i | input | 1 | DCO clock |
| xt2_clk_i | input | 1 | Second crystal clock |
| aux_clk_o | output | 1 | Auxiliary clock |
| main_clk_o | output | 1 | Main clock |
| sub_clk_o | output | 1 | Subsystem clock |

## Verification
The bench builds the block with HAS_XT2 = 1 and MAX_DIV_LOG2 = 5, so code 2 reaches a real second source and codes 6 and 7 show the divide saturation. STABLE_CYCLES is cut to 64. With that value the fault fallback, the automatic clear and the software clear all fall inside a few microseconds. Each source runs at a distinct period, so one measured output period identifies both the selected source and the divide ratio.

// File: rtl/clkgen_pkg.sv
// Shared constants and source decoding for the clock selector.
// Assumes four sources with fixed indices and 3-bit per-output codes.
package clkgen_pkg;
    localparam int NUM_SRC = 4;
    localparam int NUM_OUT = 3;
    localparam int CODE_W  = 3;
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int REG_W   = 16;

    localparam logic [SRC_W-1:0] SRC_XT  = 2'd0;
    localparam logic [SRC_W-1:0] SRC_VLO = 2'd1;
    localparam logic [SRC_W-1:0] SRC_XT2 = 2'd2;
    localparam logic [SRC_W-1:0] SRC_DCO = 2'd3;

    localparam logic [1:0] ADDR_KEY = 2'd0;
    localparam logic [1:0] ADDR_SEL = 2'd1;
    localparam logic [1:0] ADDR_DIV = 2'd2;
    localparam logic [1:0] ADDR_FLT = 2'd3;

    localparam logic [7:0]       UNLOCK_KEY = 8'hA5;
    localparam logic [REG_W-1:0] CFG_MASK   = 16'h0777;
    localparam logic [REG_W-1:0] SEL_RESET  = 16'h0330;
    localparam logic [REG_W-1:0] DIV_RESET  = 16'h0330;

    // Map a software source code to a source index.
    function automatic logic [SRC_W-1:0] decode_src(input logic [CODE_W-1:0] code,
                                                    input bit has_xt2);
        case (code)
            3'd0:    return SRC_XT;
            3'd1:    return SRC_VLO;
            3'd2:    return has_xt2 ? SRC_XT2 : SRC_DCO;
            default: return SRC_DCO;
        endcase
    endfunction
endpackage

// File: rtl/clkgen_regs.sv
// Register file with unlock key, sticky violation flag and the crystal
// fault flag. All state is in the bus clock domain; xt_stable_i arrives
// asynchronously from the crystal domain and is synchronized here.
module clkgen_regs
    import clkgen_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic [1:0]       rd_addr_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic             pin_en_i,
    input  logic             xt_stable_i,
    output logic             xt_en_o,
    output logic             fault_o,
    output logic             unlocked_o,
    output logic             viol_o,
    output logic             stable_o,
    output logic [REG_W-1:0] sel_word_o,
    output logic [REG_W-1:0] div_word_o
);
    logic unlocked_q, viol_q, fault_q, xt_en_q, xt_en_d;
    logic stab_s1, stab_s2;
    logic [REG_W-1:0] sel_q, div_q;
    logic key_wr, cfg_wr, sw_clr, set_cond;

    assign key_wr   = wr_en_i && (wr_addr_i == ADDR_KEY);
    assign cfg_wr   = wr_en_i && (wr_addr_i != ADDR_KEY) && unlocked_q;
    assign sw_clr   = cfg_wr && (wr_addr_i == ADDR_FLT) && wr_data_i[0];
    assign set_cond = (xt_en_q && !xt_en_d) || (xt_en_q && !stab_s2);

    // Lock state and sticky violation flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            unlocked_q <= 1'b0;
            viol_q     <= 1'b0;
        end else begin
            if (key_wr) unlocked_q <= (wr_data_i[15:8] == UNLOCK_KEY);
            if (wr_en_i && !key_wr && !unlocked_q) viol_q <= 1'b1;
        end
    end

    // Source and divider configuration words.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sel_q <= SEL_RESET;
            div_q <= DIV_RESET;
        end else if (cfg_wr) begin
            if (wr_addr_i == ADDR_SEL) sel_q <= wr_data_i & CFG_MASK;
            if (wr_addr_i == ADDR_DIV) div_q <= wr_data_i & CFG_MASK;
        end
    end

    // Crystal enable capture, stability synchronizer and fault flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            xt_en_q <= 1'b0;
            xt_en_d <= 1'b0;
            stab_s1 <= 1'b0;
            stab_s2 <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            xt_en_q <= pin_en_i;
            xt_en_d <= xt_en_q;
            stab_s1 <= xt_stable_i;
            stab_s2 <= stab_s1;
            if (set_cond)     fault_q <= 1'b1;
            else if (sw_clr)  fault_q <= 1'b0;
            else if (stab_s2) fault_q <= 1'b0;
        end
    end

    // Combinational read mux.
    always_comb begin
        case (rd_addr_i)
            ADDR_KEY: rd_data_o = {14'd0, viol_q, unlocked_q};
            ADDR_SEL: rd_data_o = sel_q;
            ADDR_DIV: rd_data_o = div_q;
            default:  rd_data_o = {14'd0, stab_s2, fault_q};
        endcase
    end

    assign xt_en_o    = xt_en_q;
    assign fault_o    = fault_q;
    assign unlocked_o = unlocked_q;
    assign viol_o     = viol_q;
    assign stable_o   = stab_s2;
    assign sel_word_o = sel_q;
    assign div_word_o = div_q;
endmodule

// File: rtl/clkgen_xt_mon.sv
// Crystal stability counter and crystal clock gate. Assumes the raw
// crystal clock keeps running; the counter is held clear while disabled.
module clkgen_xt_mon #(
    parameter int STABLE_CYCLES = 4096
) (
    input  logic xt_clk_i,
    input  logic rst_ni,
    input  logic xt_en_i,
    output logic stable_o,
    output logic xt_clk_o
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic stable_q, gate_s1, gate_s2, xt_rst_n;

    assign xt_rst_n = rst_ni && xt_en_i;

    // Count crystal cycles since enable until the stability limit.
    always_ff @(posedge xt_clk_i or negedge xt_rst_n) begin
        if (!xt_rst_n) begin
            cnt_q    <= '0;
            stable_q <= 1'b0;
        end else if (!stable_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(STABLE_CYCLES - 1)) stable_q <= 1'b1;
        end
    end

    // Gate the crystal clock on its falling edge from the enable.
    always_ff @(negedge xt_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gate_s1 <= 1'b0;
            gate_s2 <= 1'b0;
        end else begin
            gate_s1 <= xt_en_i;
            gate_s2 <= gate_s1;
        end
    end

    assign stable_o = stable_q;
    assign xt_clk_o = xt_clk_i & gate_s2;
endmodule

// File: rtl/clkgen_gf_mux.sv
// Glitch-free N-way clock multiplexer. A source enables only after every
// other enable has dropped; each enable passes two falling-edge flops of
// its own clock. Sync flops use the free-running clocks, the data path
// the (possibly gated) clocks.
module clkgen_gf_mux #(
    parameter int N = 4
) (
    input  logic [N-1:0]         sync_clk_i,
    input  logic [N-1:0]         src_clk_i,
    input  logic                 rst_ni,
    input  logic [$clog2(N)-1:0] sel_i,
    output logic                 clk_o
);
    localparam int SEL_W = $clog2(N);

    logic [N-1:0] en;

    for (genvar i = 0; i < N; i++) begin : g_src
        logic s1_q, en_q, req;
        assign req   = (sel_i == SEL_W'(i)) && ((en & ~(N'(1) << i)) == '0);
        assign en[i] = en_q;

        // Two-stage falling-edge synchronizer of the request.
        always_ff @(negedge sync_clk_i[i] or negedge rst_ni) begin
            if (!rst_ni) begin
                s1_q <= 1'b0;
                en_q <= 1'b0;
            end else begin
                s1_q <= req;
                en_q <= s1_q;
            end
        end
    end

    assign clk_o = |(src_clk_i & en);
endmodule

// File: rtl/clkgen_pow2_div.sv
// Power-of-two clock divider by falling-edge gating: the output passes one
// input high phase in every 2^n. Assumes the code is quasi-static; it is
// resynchronized into the input clock domain.
module clkgen_pow2_div #(
    parameter int CODE_W   = 3,
    parameter int MAX_LOG2 = 5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] code_i,
    output logic              clk_o
);
    localparam int CNT_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;

    logic [CODE_W-1:0] code_s1, code_s2, lg;
    logic [CNT_W-1:0]  cnt_q, cnt_nxt, mask;
    logic [CNT_W:0]    mask_w;
    logic              gate_q;

    assign lg      = (code_s2 > CODE_W'(MAX_LOG2)) ? CODE_W'(MAX_LOG2) : code_s2;
    assign mask_w  = ((CNT_W + 1)'(1) << lg) - 1'b1;
    assign mask    = mask_w[CNT_W-1:0];
    assign cnt_nxt = cnt_q + 1'b1;

    // Resynchronize code, advance counter and update the gate.
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            code_s1 <= '0;
            code_s2 <= '0;
            cnt_q   <= '0;
            gate_q  <= 1'b0;
        end else begin
            code_s1 <= code_i;
            code_s2 <= code_s1;
            cnt_q   <= cnt_nxt;
            gate_q  <= ((cnt_nxt & mask) == '0);
        end
    end

    assign clk_o = clk_i & gate_q;
endmodule

// File: rtl/clkgen_sel_div.sv
// Top: registers, crystal monitor and one mux plus divider per output.
// Output 0 is auxiliary (with crystal fault fallback), 1 main, 2 subsystem.
module clkgen_sel_div
    import clkgen_pkg::*;
#(
    parameter bit HAS_XT2       = 1'b1,
    parameter int STABLE_CYCLES = 4096,
    parameter int MAX_DIV_LOG2  = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic [1:0]       rd_addr_i,
    output logic [REG_W-1:0] rd_data_o,
    input  logic             xt_pin_en_i,
    input  logic             xt_clk_i,
    input  logic             vlo_clk_i,
    input  logic             dco_clk_i,
    input  logic             xt2_clk_i,
    output logic             aux_clk_o,
    output logic             main_clk_o,
    output logic             sub_clk_o
);
    logic xt_en, fault, unlocked, viol, stable_s, xt_stable, xt_gated;
    logic [REG_W-1:0]   sel_word, div_word;
    logic [NUM_SRC-1:0] sync_clks, data_clks;
    logic [NUM_OUT-1:0] out_clk;

    clkgen_regs u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .pin_en_i(xt_pin_en_i), .xt_stable_i(xt_stable),
        .xt_en_o(xt_en), .fault_o(fault), .unlocked_o(unlocked),
        .viol_o(viol), .stable_o(stable_s),
        .sel_word_o(sel_word), .div_word_o(div_word)
    );

    clkgen_xt_mon #(.STABLE_CYCLES(STABLE_CYCLES)) u_xt_mon (
        .xt_clk_i(xt_clk_i), .rst_ni(rst_ni), .xt_en_i(xt_en),
        .stable_o(xt_stable), .xt_clk_o(xt_gated)
    );

    assign sync_clks = {dco_clk_i, xt2_clk_i, vlo_clk_i, xt_clk_i};
    assign data_clks = {dco_clk_i, xt2_clk_i, vlo_clk_i, xt_gated};

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
        logic [CODE_W-1:0] sel_code, div_code;
        logic [SRC_W-1:0]  src_idx;
        logic              mux_clk;

        assign sel_code = sel_word[4*g +: CODE_W];
        assign div_code = div_word[4*g +: CODE_W];

        if (g == 0) begin : g_fallback
            // Auxiliary source pick with crystal fault fallback.
            always_comb begin
                if (fault && sel_code == 3'd0) src_idx = SRC_VLO;
                else                           src_idx = decode_src(sel_code, HAS_XT2);
            end
        end else begin : g_plain
            // Plain source pick.
            always_comb src_idx = decode_src(sel_code, HAS_XT2);
        end

        clkgen_gf_mux #(.N(NUM_SRC)) u_mux (
            .sync_clk_i(sync_clks), .src_clk_i(data_clks),
            .rst_ni(rst_ni), .sel_i(src_idx), .clk_o(mux_clk)
        );

        clkgen_pow2_div #(.CODE_W(CODE_W), .MAX_LOG2(MAX_DIV_LOG2)) u_div (
            .clk_i(mux_clk), .rst_ni(rst_ni), .code_i(div_code), .clk_o(out_clk[g])
        );
    end

    assign aux_clk_o  = out_clk[0];
    assign main_clk_o = out_clk[1];
    assign sub_clk_o  = out_clk[2];
endmodule

// File: rtl/clkgen_sel_div_chk.sv
// Bus-domain property checker for clkgen_sel_div, attached by bind.
module clkgen_sel_div_chk
    import clkgen_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [1:0]       wr_addr_i,
    input logic [REG_W-1:0] wr_data_i,
    input logic             unlocked,
    input logic             viol,
    input logic             xt_en,
    input logic             fault,
    input logic             stable_s,
    input logic [REG_W-1:0] sel_word,
    input logic [REG_W-1:0] div_word
);
    a_r4_unlock_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == ADDR_KEY && wr_data_i[15:8] == UNLOCK_KEY) |=> unlocked);

    a_r4_relock_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == ADDR_KEY && wr_data_i[15:8] != UNLOCK_KEY) |=> !unlocked);

    a_r5_locked_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i != ADDR_KEY && !unlocked)
        |=> ($stable(sel_word) && $stable(div_word) && viol));

    a_r5_violation_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        viol |=> viol);

    a_r7_fault_on_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(xt_en) |=> fault);

    a_r7_fault_until_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xt_en && !stable_s) |=> fault);
endmodule

bind clkgen_sel_div clkgen_sel_div_chk u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .unlocked(unlocked), .viol(viol), .xt_en(xt_en),
    .fault(fault), .stable_s(stable_s), .sel_word(sel_word), .div_word(div_word)
);

// File: tb/clkgen_sel_div_tb.sv
`timescale 1ns/1ps
module clkgen_sel_div_tb;
    // Source periods (ns): crystal 62, internal osc 94, DCO 10, second crystal 26.
    logic clk = 0, rst_n = 0;
    logic xt = 0, vlo = 0, dco = 0, xt2 = 0;
    logic wr_en = 0, pin_en = 0;
    logic [1:0] wr_addr = 0, rd_addr = 0;
    logic [15:0] wr_data = 0, rd_data;
    logic aux, mainc, sub;

    int total = 0, bad = 0, glitches = 0;
    bit rst_done = 0, finished = 0;
    real last_t[3], prev_t[3], chg_t[3];
    int  ecnt[3];

    always #4  clk = ~clk;
    always #31 xt  = ~xt;
    always #47 vlo = ~vlo;
    always #5  dco = ~dco;
    always #13 xt2 = ~xt2;

    clkgen_sel_div #(.HAS_XT2(1'b1), .STABLE_CYCLES(64), .MAX_DIV_LOG2(5)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .xt_pin_en_i(pin_en), .xt_clk_i(xt), .vlo_clk_i(vlo), .dco_clk_i(dco),
        .xt2_clk_i(xt2), .aux_clk_o(aux), .main_clk_o(mainc), .sub_clk_o(sub)
    );

    // Edge timing per output.
    always @(posedge aux)   begin prev_t[0] = last_t[0]; last_t[0] = $realtime; ecnt[0]++; end
    always @(posedge mainc) begin prev_t[1] = last_t[1]; last_t[1] = $realtime; ecnt[1]++; end
    always @(posedge sub)   begin prev_t[2] = last_t[2]; last_t[2] = $realtime; ecnt[2]++; end

    // R6: shortest phase monitor (shortest source half period is 5 ns).
    always @(aux)   begin if (rst_done && chg_t[0] > 0 && ($realtime - chg_t[0]) < 4.5) glitches++; chg_t[0] = $realtime; end
    always @(mainc) begin if (rst_done && chg_t[1] > 0 && ($realtime - chg_t[1]) < 4.5) glitches++; chg_t[1] = $realtime; end
    always @(sub)   begin if (rst_done && chg_t[2] > 0 && ($realtime - chg_t[2]) < 4.5) glitches++; chg_t[2] = $realtime; end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
    endtask

    task automatic rd_chk(string req, logic [1:0] a, logic [15:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(req, int'(rd_data), int'(exp));
    endtask

    task automatic period_chk(string req, int which, int exp_ns, int settle_ns);
        int p;
        #(settle_ns);
        p = (($realtime - last_t[which]) < 2.0 * exp_ns + 1.0) ?
            int'(last_t[which] - prev_t[which]) : -1;
        chk(req, p, exp_ns);
    endtask

    task automatic quiet_chk(string req, int which);
        int c0;
        #500;
        c0 = ecnt[which];
        #2000;
        chk(req, ecnt[which] - c0, 0);
    endtask

    // R1: reset defaults.
    task automatic t_reset();
        rd_chk("R1 select word", 2'd1, 16'h0330);
        rd_chk("R1 divide word", 2'd2, 16'h0330);
        rd_chk("R4 locked after reset", 2'd0, 16'h0000);
        period_chk("R1 main DCO/8", 1, 80, 3000);
        period_chk("R1 sub DCO/8", 2, 80, 100);
        quiet_chk("R1 R9 aux quiet, crystal off", 0);
    endtask

    // R5: locked writes are dropped and flagged.
    task automatic t_locked();
        wr(2'd1, 16'h0111);
        rd_chk("R5 select unchanged", 2'd1, 16'h0330);
        rd_chk("R5 violation set", 2'd0, 16'h0002);
        period_chk("R5 main unchanged", 1, 80, 2000);
    endtask

    // R4, R2: unlock then pick every source code.
    task automatic t_select();
        wr(2'd0, 16'hA500);
        rd_chk("R4 unlocked, R5 viol kept", 2'd0, 16'h0003);
        wr(2'd2, 16'h0000);
        wr(2'd1, 16'h0213);
        rd_chk("R2 select readback", 2'd1, 16'h0213);
        period_chk("R2 aux code3 DCO", 0, 10, 4000);
        period_chk("R2 main code1 osc", 1, 94, 100);
        period_chk("R2 sub code2 second crystal", 2, 26, 100);
        wr(2'd1, 16'h0574);
        period_chk("R2 aux code4 DCO", 0, 10, 4000);
        period_chk("R2 main code7 DCO", 1, 10, 100);
        period_chk("R2 sub code5 DCO", 2, 10, 100);
    endtask

    // R3: divide codes including saturation.
    task automatic t_divide();
        wr(2'd1, 16'h0333);
        wr(2'd2, 16'h0651);
        period_chk("R3 aux code1 /2", 0, 20, 4000);
        period_chk("R3 main code5 /32", 1, 320, 100);
        period_chk("R3 sub code6 /32", 2, 320, 100);
        wr(2'd2, 16'h0024);
        period_chk("R3 aux code4 /16", 0, 160, 4000);
        period_chk("R3 main code2 /4", 1, 40, 100);
        period_chk("R3 sub code0 /1", 2, 10, 100);
    endtask

    // R4, R5: relock with a wrong key.
    task automatic t_relock();
        wr(2'd0, 16'h1200);
        rd_chk("R4 relocked", 2'd0, 16'h0002);
        wr(2'd2, 16'h0777);
        rd_chk("R5 divide unchanged while locked", 2'd2, 16'h0024);
        wr(2'd0, 16'hA5FF);
        wr(2'd2, 16'h0000);
    endtask

    // R7, R8: fault fallback and automatic clear.
    task automatic t_fault();
        wr(2'd1, 16'h0330);
        @(negedge clk); pin_en = 1;
        #200;
        rd_chk("R7 fault set after enable", 2'd3, 16'h0001);
        period_chk("R8 aux on osc while faulted", 0, 94, 1200);
        #5000;
        rd_chk("R7 fault cleared when stable", 2'd3, 16'h0002);
        period_chk("R8 aux on crystal when stable", 0, 62, 1500);
    endtask

    // R7, R8, R9: restart, software clear, crystal gated off.
    task automatic t_swclear();
        @(negedge clk); pin_en = 0;
        quiet_chk("R9 aux quiet after disable", 0);
        @(negedge clk); pin_en = 1;
        #300;
        @(negedge clk); pin_en = 0;
        rd_chk("R7 fault set on restart", 2'd3, 16'h0001);
        period_chk("R8 aux on osc after restart", 0, 94, 1500);
        wr(2'd3, 16'h0001);
        rd_chk("R7 software clear", 2'd3, 16'h0000);
        quiet_chk("R9 aux gated crystal after clear", 0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            last_t[i] = 0; prev_t[i] = 0; chg_t[i] = 0; ecnt[i] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1;
        rst_done = 1;
        t_reset();
        t_locked();
        t_select();
        t_divide();
        t_relock();
        t_fault();
        t_swclear();
        chk("R6 no short clock phase", glitches, 0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule